// File: doc/BRIEF.md
# UART interrupt status and control registers

This block is the register front end of a fast serial port. It holds the port's configuration word and baud divider. It gathers event information from the serial datapath and turns it into one interrupt line. The datapath is a separate block: it reports the fill levels of its transmit and receive FIFOs, a receive-idle indication, and one-cycle pulses for framing errors, received breaks and receive overruns. In return it takes the configuration fields, such as break forcing, hardware flow-control settings, FIFO trigger selections, the idle-timeout selection, the sample offset and the divider.

Software reaches the block through a plain 32-bit register port addressed by byte offset. Five word offsets are in use: data, level, interrupt status, control and rate. Three of the status bits are error latches, and writing 1 clears them. The transmit status bit is also a latch: it sets when the transmit FIFO drains to its trigger level, and software can clear it or force it. The receive-trigger and receive-idle bits follow live conditions and cannot be latched. The interrupt output combines the three groups, which are transmit, receive and error, and each group has its own enable bit.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the control word, the status word and the interrupt output are 0, and the rate register and the `baud_div` output are 0xFF.
- R2: The control word at offset 0x0C stores bits 21:0 and reads 0 in bits 31:22. The fields decode as follows: tx trigger select 1:0, rx trigger select 4:2, tx enable 5, rx enable 6, error enable 7, break force 8, sample offset 13:9, CTS enable 14, CTS invert 15, idle select 17:16, RTS enable 18, RTS trigger 20:19 and RTS invert 21. Each field drives the matching output port.
- R3: The rate register at offset 0x10 stores bits 7:0, reads 0 above them and drives `baud_div`.
- R4: A read of offset 0x04 returns the receive level in bits 7:0 and the transmit level in bits 15:8, with 0 above them.
- R5: Pulses on `ev_frame`, `ev_break` and `ev_overrun` set status bits 3, 4 and 5 at offset 0x08, and those bits hold until software writes 1 to them. Writing 0, or writing 1 to a different bit, leaves them unchanged.
- R6: Status bit 0 sets in the cycle after the transmit level goes from above the selected threshold to at or below it. The tx trigger select codes 0, 1, 2 and 3 mean thresholds of 0, 4, 8 and 16. The bit does not set again while the level stays at or below the threshold.
- R7: Writing 1 to status bit 6 sets status bit 0. Writing 1 to status bit 0 clears it. When both are written together, the set takes effect.
- R8: Status bit 1 reads 1 when the receive level is at or above the threshold chosen by the rx trigger select. Codes 0 to 5 give 1, 4, 8, 16, 32 and 48, and codes 6 and 7 give 48. Status bit 2 reads `rx_idle`. Writes do not change bits 1 and 2.
- R9: `irq` is 1 when any of three conditions holds: status bit 0 with tx enable, status bit 1 or 2 with rx enable, or any of status bits 3 to 5 with error enable.
- R10: When an event and a clearing write reach the same latch in the same cycle, the latch ends up set.
- R11: Writes to offset 0x00, to unmapped offsets or to unaligned offsets change no register. Reads of offset 0x00 or of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_level | input | 8 | Transmit FIFO fill level |
| rx_level | input | 8 | Receive FIFO fill level |
| rx_idle | input | 1 | Receive idle timeout condition |
| ev_frame | input | 1 | Framing error pulse |
| ev_break | input | 1 | Break received pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| irq | output | 1 | Interrupt request |
| brk_force | output | 1 | Force the line into break |
| cts_en | output | 1 | Hardware CTS enable |
| cts_inv | output | 1 | CTS polarity invert |
| rts_en | output | 1 | Hardware RTS enable |
| rts_inv | output | 1 | RTS polarity invert |
| rts_trig | output | 2 | RTS trigger select |
| idle_sel | output | 2 | Receive idle timeout select |
| sample_ofs | output | 5 | Receive sample offset |
| rx_trig_sel | output | 3 | Receive trigger select |
| tx_trig_sel | output | 2 | Transmit trigger select |
| baud_div | output | 8 | Baud divider |

## Verification
Two things can reach the same status latch in one clock. One is a new hardware event, either an error pulse or the transmit level falling through its threshold. The other is a software write that clears that same latch. The bench drives a break pulse and a write-1-to-clear of bit 4 in one cycle. It also lowers the transmit level below its threshold in the same cycle as a clear of bit 0, and it writes the force and clear bits of the transmit latch together. In each of these cases the status read afterwards must show the latch set, and a later clear on its own must then empty it.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADR_W   = 5;
  localparam int unsigned CTRL_W  = 22;
  localparam int unsigned NUM_ERR = 3;

  localparam logic [ADR_W-1:0] OFS_DATA  = 5'h00;
  localparam logic [ADR_W-1:0] OFS_LEVEL = 5'h04;
  localparam logic [ADR_W-1:0] OFS_STAT  = 5'h08;
  localparam logic [ADR_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [ADR_W-1:0] OFS_RATE  = 5'h10;

  // status bit positions; error latches occupy ST_FRAME .. ST_FRAME+NUM_ERR-1
  localparam int unsigned ST_TX     = 0;
  localparam int unsigned ST_RXTRIG = 1;
  localparam int unsigned ST_RXIDLE = 2;
  localparam int unsigned ST_FRAME  = 3;
  localparam int unsigned ST_TXSET  = 6;

  // control word, MSB first; bit positions are the software contract
  typedef struct packed {
    logic       rts_inv;   // 21
    logic [1:0] rts_trig;  // 20:19
    logic       rts_en;    // 18
    logic [1:0] idle_sel;  // 17:16
    logic       cts_inv;   // 15
    logic       cts_en;    // 14
    logic [4:0] ofs;       // 13:9
    logic       brk;       // 8
    logic       err_ie;    // 7
    logic       rx_ie;     // 6
    logic       tx_ie;     // 5
    logic [2:0] rx_tl;     // 4:2
    logic [1:0] tx_tl;     // 1:0
  } ctrl_t;

  function automatic int unsigned tx_thr(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int unsigned rx_thr(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction
endpackage

// File: rtl/uart_rst_sync.sv
`timescale 1ns/1ps
module uart_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_ctrl_regs.sv
`timescale 1ns/1ps
module uart_ctrl_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned          RATE_W   = 8,
  parameter logic [RATE_W-1:0]    RATE_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              rate_we,
  input  logic [REG_W-1:0]  wdata,
  output ctrl_t             ctrl,
  output logic [RATE_W-1:0] rate
);
  ctrl_t             ctrl_d, ctrl_q;
  logic [RATE_W-1:0] rate_d, rate_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[REG_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    rate_d = wdata[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rate_q <= RATE_RST;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (rate_we) rate_q <= rate_d;
    end
  end

  assign ctrl = ctrl_q;
  assign rate = rate_q;
endmodule

// File: rtl/uart_evt_latch.sv
`timescale 1ns/1ps
module uart_evt_latch
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_we,
  input  logic [REG_W-1:0]   wdata,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [1:0]         tx_tl,
  input  logic [NUM_ERR-1:0] ev_err,
  output logic               tx_lat,
  output logic [NUM_ERR-1:0] err_lat
);
  logic               tx_below, tx_above_q, tx_fall;
  logic               tx_set, tx_clr, tx_lat_d, tx_lat_q;
  logic [NUM_ERR-1:0] err_d, err_q;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata[REG_W-1:ST_TXSET+1], wdata[ST_RXIDLE:ST_RXTRIG]};

  // transmit event: level crosses from above the threshold to at/below it
  assign tx_below = 32'(tx_level) <= tx_thr(tx_tl);
  assign tx_fall  = tx_above_q & tx_below;
  assign tx_set   = tx_fall | (stat_we & wdata[ST_TXSET]);
  assign tx_clr   = stat_we & wdata[ST_TX];

  always_comb begin
    tx_lat_d = tx_set | (tx_lat_q & ~tx_clr);
  end

  // error latches: a new event takes priority over a clearing write
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    logic clr_i;
    assign clr_i    = stat_we & wdata[ST_FRAME+i];
    assign err_d[i] = ev_err[i] | (err_q[i] & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_above_q <= 1'b0;
      tx_lat_q   <= 1'b0;
      err_q      <= '0;
    end else begin
      tx_above_q <= ~tx_below;
      tx_lat_q   <= tx_lat_d;
      err_q      <= err_d;
    end
  end

  assign tx_lat  = tx_lat_q;
  assign err_lat = err_q;
endmodule

// File: rtl/uart_irq_merge.sv
`timescale 1ns/1ps
module uart_irq_merge
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [2:0]         rx_tl,
  input  logic               rx_idle,
  input  logic               tx_lat,
  input  logic [NUM_ERR-1:0] err_lat,
  input  logic [2:0]         ie_vec,   // {err, rx, tx}
  output logic               rx_trig,
  output logic               irq
);
  logic grp_tx, grp_rx, grp_err;

  assign rx_trig = 32'(rx_level) >= rx_thr(rx_tl);

  always_comb begin
    grp_tx  = tx_lat & ie_vec[0];
    grp_rx  = (rx_trig | rx_idle) & ie_vec[1];
    grp_err = (|err_lat) & ie_vec[2];
    irq     = grp_tx | grp_rx | grp_err;
  end
endmodule

// File: rtl/uart_irq_regs.sv
`timescale 1ns/1ps
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_idle,
  input  logic              ev_frame,
  input  logic              ev_break,
  input  logic              ev_overrun,
  output logic              irq,
  output logic              brk_force,
  output logic              cts_en,
  output logic              cts_inv,
  output logic              rts_en,
  output logic              rts_inv,
  output logic [1:0]        rts_trig,
  output logic [1:0]        idle_sel,
  output logic [4:0]        sample_ofs,
  output logic [2:0]        rx_trig_sel,
  output logic [1:0]        tx_trig_sel,
  output logic [RATE_W-1:0] baud_div
);
  ctrl_t              ctrl;
  logic               rst_s_n;
  logic               ctrl_we, rate_we, stat_we;
  logic               tx_lat, rx_trig;
  logic [NUM_ERR-1:0] err_lat;
  logic [2:0]         ie_vec;

  assign ctrl_we = reg_wr && (reg_addr == OFS_CTRL);
  assign rate_we = reg_wr && (reg_addr == OFS_RATE);
  assign stat_we = reg_wr && (reg_addr == OFS_STAT);
  assign ie_vec  = {ctrl.err_ie, ctrl.rx_ie, ctrl.tx_ie};

  uart_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  uart_ctrl_regs #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .ctrl_we(ctrl_we), .rate_we(rate_we),
    .wdata(reg_wdata), .ctrl(ctrl), .rate(baud_div)
  );

  uart_evt_latch #(.LVL_W(LVL_W)) u_evt (
    .clk(clk), .rst_n(rst_s_n), .stat_we(stat_we), .wdata(reg_wdata),
    .tx_level(tx_level), .tx_tl(ctrl.tx_tl),
    .ev_err({ev_overrun, ev_break, ev_frame}),
    .tx_lat(tx_lat), .err_lat(err_lat)
  );

  uart_irq_merge #(.LVL_W(LVL_W)) u_irq (
    .rx_level(rx_level), .rx_tl(ctrl.rx_tl), .rx_idle(rx_idle),
    .tx_lat(tx_lat), .err_lat(err_lat), .ie_vec(ie_vec),
    .rx_trig(rx_trig), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_LEVEL: begin
        reg_rdata[LVL_W-1:0]       = rx_level;
        reg_rdata[2*LVL_W-1:LVL_W] = tx_level;
      end
      OFS_STAT: begin
        reg_rdata[ST_TX]              = tx_lat;
        reg_rdata[ST_RXTRIG]          = rx_trig;
        reg_rdata[ST_RXIDLE]          = rx_idle;
        reg_rdata[ST_FRAME+:NUM_ERR]  = err_lat;
      end
      OFS_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
      OFS_RATE: reg_rdata[RATE_W-1:0] = baud_div;
      default:  reg_rdata = '0;
    endcase
  end

  assign brk_force   = ctrl.brk;
  assign cts_en      = ctrl.cts_en;
  assign cts_inv     = ctrl.cts_inv;
  assign rts_en      = ctrl.rts_en;
  assign rts_inv     = ctrl.rts_inv;
  assign rts_trig    = ctrl.rts_trig;
  assign idle_sel    = ctrl.idle_sel;
  assign sample_ofs  = ctrl.ofs;
  assign rx_trig_sel = ctrl.rx_tl;
  assign tx_trig_sel = ctrl.tx_tl;
endmodule

// File: rtl/uart_irq_regs_chk.sv
`timescale 1ns/1ps
module uart_irq_regs_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADR_W-1:0]  reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              ev_frame,
  input logic              ev_break,
  input logic              ev_overrun,
  input logic              tx_lat,
  input logic [NUM_ERR-1:0] err_lat,
  input logic [2:0]        ie_vec,
  input logic              irq,
  input logic [RATE_W-1:0] baud_div
);
  logic stat_wr, rate_wr, other_wr;
  assign stat_wr  = reg_wr && (reg_addr == OFS_STAT);
  assign rate_wr  = reg_wr && (reg_addr == OFS_RATE);
  assign other_wr = reg_wr && (reg_addr != OFS_RATE);

  // R5: a clear of the break latch with no new break empties it
  p_brk_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[ST_FRAME+1] && !ev_break) |=> !err_lat[1]);

  // R5: the overrun latch holds unless explicitly cleared
  p_ovr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_lat[2] && !(stat_wr && reg_wdata[ST_FRAME+2])) |=> err_lat[2]);

  // R10: a framing pulse always leaves its latch set
  p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> err_lat[0]);

  // R10: overrun pulse wins too
  p_ovr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> err_lat[2]);

  // R7: the force bit sets the transmit latch
  p_tx_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[ST_TXSET]) |=> tx_lat);

  // R9: no enabled group means no interrupt
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_vec == 3'b000) |-> !irq);

  // R3: a rate write lands on the divider output
  p_rate_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> (baud_div == $past(reg_wdata[RATE_W-1:0])));

  // R11: no other write moves the divider
  p_rate_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> $stable(baud_div));
endmodule

bind uart_irq_regs uart_irq_regs_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ev_frame(ev_frame), .ev_break(ev_break),
  .ev_overrun(ev_overrun), .tx_lat(tx_lat), .err_lat(err_lat),
  .ie_vec(ie_vec), .irq(irq), .baud_div(baud_div)
);

// File: tb/test_uart_irq_regs.sv
`timescale 1ns/1ps
module test_uart_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_level, rx_level;
  logic        rx_idle, ev_frame, ev_break, ev_overrun;
  logic        irq, brk_force, cts_en, cts_inv, rts_en, rts_inv;
  logic [1:0]  rts_trig, idle_sel, tx_trig_sel;
  logic [4:0]  sample_ofs;
  logic [2:0]  rx_trig_sel;
  logic [7:0]  baud_div;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [4:0] A_DATA = 5'h00, A_LVL = 5'h04, A_STAT = 5'h08,
                         A_CTRL = 5'h0C, A_RATE = 5'h10;

  always #10 clk = ~clk;

  uart_irq_regs i_uart_irq_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
    .rx_level(rx_level), .rx_idle(rx_idle), .ev_frame(ev_frame),
    .ev_break(ev_break), .ev_overrun(ev_overrun), .irq(irq),
    .brk_force(brk_force), .cts_en(cts_en), .cts_inv(cts_inv),
    .rts_en(rts_en), .rts_inv(rts_inv), .rts_trig(rts_trig),
    .idle_sel(idle_sel), .sample_ofs(sample_ofs), .rx_trig_sel(rx_trig_sel),
    .tx_trig_sel(tx_trig_sel), .baud_div(baud_div)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int txt(input int s);
    return (s == 0) ? 0 : (1 << (s + 1));
  endfunction

  function automatic int rxt(input int s);
    if (s == 0) return 1;
    if (s <= 3) return 1 << (s + 1);
    if (s == 4) return 32;
    return 48;
  endfunction

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog (all requirements) got=running exp=finished");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    tx_level = 0; rx_level = 0; rx_idle = 0;
    ev_frame = 0; ev_break = 0; ev_overrun = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_RATE, v); chk("R1 rate", v, 32'hFF);
    chk("R1 baud_div", baud_div, 8'hFF);
    chk("R1 irq", irq, 0);

    // R2 walking one over the control word
    for (int b = 0; b < 32; b++) begin
      wr(A_CTRL, 32'h1 << b);
      rd(A_CTRL, v);
      chk("R2 walk", v, (b < 22) ? (32'h1 << b) : 32'h0);
    end
    // R2 field decode to output ports, two complementary patterns
    for (int k = 0; k < 2; k++) begin
      pat = (k == 0) ? 32'h002A_5A5A : 32'h0015_A5A5;
      wr(A_CTRL, pat);
      chk("R2 tx_trig_sel", tx_trig_sel, pat & 3);
      chk("R2 rx_trig_sel", rx_trig_sel, (pat >> 2) & 7);
      chk("R2 brk_force", brk_force, (pat >> 8) & 1);
      chk("R2 sample_ofs", sample_ofs, (pat >> 9) & 31);
      chk("R2 cts_en", cts_en, (pat >> 14) & 1);
      chk("R2 cts_inv", cts_inv, (pat >> 15) & 1);
      chk("R2 idle_sel", idle_sel, (pat >> 16) & 3);
      chk("R2 rts_en", rts_en, (pat >> 18) & 1);
      chk("R2 rts_trig", rts_trig, (pat >> 19) & 3);
      chk("R2 rts_inv", rts_inv, (pat >> 21) & 1);
    end
    wr(A_CTRL, 0);

    // R3 rate register
    wr(A_RATE, 32'hFFFF_FF5A);
    rd(A_RATE, v); chk("R3 rate read", v, 32'h5A);
    chk("R3 baud_div", baud_div, 8'h5A);

    // R4 level register
    tx_level = 8'hA5; rx_level = 8'h3C;
    rd(A_LVL, v); chk("R4 level", v, 32'h0000_A53C);
    tx_level = 0; rx_level = 0;
    tick();
    wr(A_STAT, 32'h39);

    // R5 error latches, W1C
    for (int i = 0; i < 3; i++) begin
      ev_frame = (i == 0); ev_break = (i == 1); ev_overrun = (i == 2);
      tick();
      ev_frame = 0; ev_break = 0; ev_overrun = 0;
      tick();
      rd(A_STAT, v); chk("R5 latch", v, 32'h8 << i);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R5 write0 keeps", v, 32'h8 << i);
      wr(A_STAT, 32'h39 & ~(32'h8 << i));
      rd(A_STAT, v); chk("R5 other bits keep", v, 32'h8 << i);
      wr(A_STAT, 32'h8 << i);
      rd(A_STAT, v); chk("R5 w1c", v, 0);
    end

    // R6 transmit threshold sweep
    for (int s = 0; s < 4; s++) begin
      wr(A_CTRL, s);
      for (int l = 0; l <= 20; l++) begin
        tx_level = 20;
        wr(A_STAT, 32'h1);
        tx_level = l[7:0];
        tick();
        rd(A_STAT, v); chk("R6 fall latch", v & 1, (l <= txt(s)) ? 1 : 0);
        wr(A_STAT, 32'h1);
        tick();
        rd(A_STAT, v); chk("R6 no relatch", v & 1, 0);
      end
    end
    tx_level = 0;
    wr(A_CTRL, 0);
    wr(A_STAT, 32'h1);

    // R7 force and clear of transmit latch
    wr(A_STAT, 32'h40);
    rd(A_STAT, v); chk("R7 force", v & 1, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R7 clear", v & 1, 0);
    wr(A_STAT, 32'h41);
    rd(A_STAT, v); chk("R7 force beats clear", v & 1, 1);
    wr(A_STAT, 32'h1);

    // R8 receive trigger sweep
    for (int s = 0; s < 8; s++) begin
      wr(A_CTRL, s << 2);
      for (int l = 0; l <= 50; l++) begin
        rx_level = l[7:0];
        rd(A_STAT, v); chk("R8 rx trig", (v >> 1) & 1, (l >= rxt(s)) ? 1 : 0);
      end
    end
    rx_level = 0;
    wr(A_CTRL, 0);
    rx_idle = 1;
    rd(A_STAT, v); chk("R8 idle bit", v, 32'h4);
    rx_idle = 0;
    wr(A_STAT, 32'h6);
    rd(A_STAT, v); chk("R8 write ignored", v, 0);

    // R9 exhaustive interrupt combine
    for (int c = 0; c < 64; c++) begin
      wr(A_STAT, 32'h39);
      wr(A_CTRL, (c & 7) << 5);
      if (c & 8) wr(A_STAT, 32'h40);
      rx_idle = (c >> 4) & 1;
      if (c & 32) begin
        ev_overrun = 1; tick(); ev_overrun = 0;
      end
      #1;
      chk("R9 irq", irq,
          (((c & 1) && (c & 8)) || ((c & 2) && (c & 16)) || ((c & 4) && (c & 32))) ? 1 : 0);
    end
    rx_idle = 0;
    wr(A_CTRL, 0);
    wr(A_STAT, 32'h39);

    // R10 event and clear in the same cycle
    ev_break = 1;
    wr(A_STAT, 32'h10);
    ev_break = 0;
    rd(A_STAT, v); chk("R10 break wins", v, 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); chk("R10 later clear", v, 0);
    wr(A_CTRL, 1);
    tx_level = 10;
    tick();
    tx_level = 2;
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R10 tx fall wins", v & 1, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R10 tx later clear", v & 1, 0);
    tx_level = 0;
    wr(A_CTRL, 0);

    // R11 unmapped / data writes change nothing
    wr(A_CTRL, 32'h0012_3456);
    wr(A_RATE, 32'h33);
    ev_frame = 1; tick(); ev_frame = 0;
    wr(A_DATA, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF);
    wr(5'h0D, 32'h0);
    rd(A_CTRL, v); chk("R11 ctrl kept", v, 32'h0012_3456);
    rd(A_RATE, v); chk("R11 rate kept", v, 32'h33);
    rd(A_STAT, v); chk("R11 stat kept", v, 32'h8);
    rd(A_DATA, v); chk("R11 data reads 0", v, 0);
    rd(5'h14, v); chk("R11 unmapped reads 0", v, 0);

    finish_up();
  end
endmodule